// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard controller for an in-order pipeline with five stages: fetch, decode, operand fetch, execute and store result. In each cycle it looks at the valid bit of every stage and the register numbers each stage carries. It also sees the jump flags from decode and execute and the memory claim from operand fetch. From these it decides which stages hold, which stages are squashed, and whether the program counter must be redirected. It also tells the datapath when the execute result should be steered back into an operand instead of the register value.

Every writer locks its destination register when it leaves decode. The lock is released when the writer retires in store result. A reader in operand fetch waits while a source is locked, unless forwarding is enabled and the writer sits in execute right now. A second writer to a register that is still locked waits in decode, so there is only ever one writer in flight per register. Unconditional jumps act at decode and squash fetch. Taken conditional jumps act at execute and squash fetch, decode and operand fetch. A squash always overrides a hold in the same cycle. Every output except the lock table is combinational on the current inputs, so the datapath uses the controls in the same cycle.

Top module: `hzd_ctl`

## Requirements
- R1: After reset no register is locked. With every stage empty, all outputs are zero, and a reader in operand fetch does not stall.
- R2: A valid writer leaving decode (`id_wr`, nonzero `id_rd`, decode not held) locks that register from the next cycle. While a source used in operand fetch is locked, `stall` reads 5'b00111. The lock is cleared the cycle after a valid store-result stage with `sr_wr` names that register, so the stall drops one cycle after that retirement.
- R3: With `fwd_en` high, a reader in operand fetch whose source matches a valid execute-stage writer gets `fwd_a`/`fwd_b` high and is not stalled for that source. With `fwd_en` low the same case stalls.
- R4: Register 0 is never locked and never forwarded. Writes to it and reads of it cause no stall and no forward select.
- R5: A valid, unsquashed operand fetch with `of_memreq` holds fetch only: `stall` = 5'b00001.
- R6: A valid unconditional jump in decode that is not held gives `flush` = 5'b00001 and a one-cycle `redirect`, with `redirect_ex` low. If decode is held, no flush and no redirect occur.
- R7: A valid, taken conditional jump in execute gives `flush` = 5'b00111, `redirect` and `redirect_ex`. A jump that is not taken has no effect.
- R8: A squash overrides a hold on the same stage. Squashed decode and operand-fetch contents set no lock, claim no memory and cause no stall.
- R9: A decode writer whose destination is already locked holds decode and fetch (`stall` = 5'b00011) until the lock clears. If a set and a clear hit the same register in one cycle, the register stays locked.
- R10: `stall[k]` holds stage k (bit 0 fetch through bit 4 store result). A hold covers the causing stage and all younger stages. `bubble[k]` = 1 means stage k receives an empty slot next cycle because stage k-1 holds while stage k advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_vld | input | 5 | Valid bit per stage, bit 0 fetch to bit 4 store result |
| id_wr | input | 1 | Decode instruction writes a register |
| id_rd | input | 3 | Decode destination register |
| id_ujmp | input | 1 | Decode instruction is an unconditional jump |
| of_use_a | input | 1 | Operand fetch reads source A |
| of_rs_a | input | 3 | Operand fetch source A register |
| of_use_b | input | 1 | Operand fetch reads source B |
| of_rs_b | input | 3 | Operand fetch source B register |
| of_memreq | input | 1 | Operand fetch wants the shared memory port |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_rd | input | 3 | Execute destination register |
| ex_cjmp | input | 1 | Execute instruction is a conditional jump |
| ex_taken | input | 1 | Conditional jump outcome |
| sr_wr | input | 1 | Store-result instruction writes a register |
| sr_rd | input | 3 | Store-result destination register |
| fwd_en | input | 1 | Allows result forwarding from execute |
| stall | output | 5 | Per-stage hold |
| flush | output | 5 | Per-stage squash |
| bubble | output | 5 | Per-stage empty-slot insert for next cycle |
| redirect | output | 1 | Program-counter redirect strobe |
| redirect_ex | output | 1 | Redirect comes from the execute-stage jump |
| fwd_a | output | 1 | Take the execute result for operand A |
| fwd_b | output | 1 | Take the execute result for operand B |

## Verification
The hardest case to reach is the set-and-clear collision on one register. It needs a decode writer and a store-result retirement naming the same register in one cycle. The only way to see the outcome is a later reader stalling in operand fetch. The stimulus sets up that exact cycle and then sends a reader to the register. A second hard case is a taken jump in execute while operand fetch is both lock-blocked and claiming memory, and decode carries a writer. The stimulus builds that state and then shows that the squashed writer left no lock behind.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NSTG  = 5;
  localparam int ST_IF = 0;
  localparam int ST_ID = 1;
  localparam int ST_OF = 2;
  localparam int ST_EX = 3;
  localparam int ST_SR = 4;
  // Squash pattern for a taken execute-stage jump: every stage younger than execute
  localparam logic [NSTG-1:0] SQ_EX = NSTG'((1 << ST_EX) - 1);
  // Squash pattern for a decode-stage jump: only fetch
  localparam logic [NSTG-1:0] SQ_ID = NSTG'((1 << ST_ID) - 1);
endpackage

// File: rtl/hzd_lock_tbl.sv
module hzd_lock_tbl #(
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_idx,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_idx,
  output logic [NREG-1:0] lock_q
);
  logic [NREG-1:0] lock_d;
  logic            upd_en;

  assign upd_en = set_en | clr_en;

  // Clear first, then set, so a set wins over a clear on the same entry
  always_comb begin
    lock_d = lock_q;
    if (clr_en) lock_d[clr_idx] = 1'b0;
    if (set_en) lock_d[set_idx] = 1'b1;
    lock_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= '0;
    else if (upd_en) lock_q <= lock_d;
  end

  AST_LOCK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_idx != '0) |=> lock_q[$past(set_idx)]); // R9
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !lock_q[$past(clr_idx)]); // R2
endmodule

// File: rtl/hzd_dep_chk.sv
module hzd_dep_chk #(
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG),
  localparam int NOPD = 2
) (
  input  logic                     fwd_en,
  input  logic [NREG-1:0]          lock_q,
  input  logic                     of_live,
  input  logic [NOPD-1:0]          use_v,
  input  logic [NOPD-1:0][RW-1:0]  rs_v,
  input  logic                     ex_wr_live,
  input  logic [RW-1:0]            ex_rd,
  input  logic                     id_wr_live,
  input  logic [RW-1:0]            id_rd,
  output logic [NOPD-1:0]          fwd_v,
  output logic                     raw_hold,
  output logic                     waw_hold
);
  logic [NOPD-1:0] wait_v;

  for (genvar g = 0; g < NOPD; g++) begin : g_opnd
    logic reads_nz;
    logic hit_ex;
    assign reads_nz  = of_live & use_v[g] & (rs_v[g] != '0);
    assign hit_ex    = fwd_en & ex_wr_live & (ex_rd == rs_v[g]);
    assign fwd_v[g]  = reads_nz & hit_ex;
    assign wait_v[g] = reads_nz & lock_q[rs_v[g]] & ~hit_ex;
  end

  assign raw_hold = |wait_v;
  assign waw_hold = id_wr_live & (id_rd != '0) & lock_q[id_rd];
endmodule

// File: rtl/hzd_seq_ctl.sv
module hzd_seq_ctl
  import hzd_pkg::*;
(
  input  logic            ex_take,
  input  logic            id_jmp,
  input  logic            mem_claim,
  input  logic            waw_hold,
  input  logic            raw_hold,
  output logic [NSTG-1:0] stall,
  output logic [NSTG-1:0] flush,
  output logic [NSTG-1:0] bubble,
  output logic            redirect,
  output logic            redirect_ex,
  output logic            id_go
);
  logic [NSTG-1:0] cause;
  logic [NSTG-1:0] hold;
  logic            ujmp_go;

  always_comb begin
    cause        = '0;
    cause[ST_IF] = mem_claim;
    cause[ST_ID] = waw_hold;
    cause[ST_OF] = raw_hold;
  end

  // A hold at a stage propagates to every younger stage
  always_comb begin
    hold[NSTG-1] = cause[NSTG-1];
    for (int k = NSTG-2; k >= 0; k--) hold[k] = hold[k+1] | cause[k];
  end

  assign ujmp_go = id_jmp & ~hold[ST_ID];
  assign id_go   = ~hold[ST_ID];

  always_comb begin
    if (ex_take)      flush = SQ_EX;
    else if (ujmp_go) flush = SQ_ID;
    else              flush = '0;
  end

  assign stall = hold & ~flush;

  always_comb begin
    bubble = '0;
    for (int k = 1; k < NSTG; k++) bubble[k] = stall[k-1] & ~stall[k];
  end

  assign redirect    = ex_take | ujmp_go;
  assign redirect_ex = ex_take;
endmodule

// File: rtl/hzd_ctl.sv
module hzd_ctl
  import hzd_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTG-1:0] stg_vld,
  input  logic            id_wr,
  input  logic [RW-1:0]   id_rd,
  input  logic            id_ujmp,
  input  logic            of_use_a,
  input  logic [RW-1:0]   of_rs_a,
  input  logic            of_use_b,
  input  logic [RW-1:0]   of_rs_b,
  input  logic            of_memreq,
  input  logic            ex_wr,
  input  logic [RW-1:0]   ex_rd,
  input  logic            ex_cjmp,
  input  logic            ex_taken,
  input  logic            sr_wr,
  input  logic [RW-1:0]   sr_rd,
  input  logic            fwd_en,
  output logic [NSTG-1:0] stall,
  output logic [NSTG-1:0] flush,
  output logic [NSTG-1:0] bubble,
  output logic            redirect,
  output logic            redirect_ex,
  output logic            fwd_a,
  output logic            fwd_b
);
  logic            ex_take, id_live, of_live, mem_claim, ex_wr_live;
  logic            raw_hold, waw_hold, id_go, set_en, clr_en;
  logic [NREG-1:0] lock_q;
  logic [1:0]      fwd_v;

  // Only a taken execute jump kills decode and operand fetch contents
  assign ex_take    = stg_vld[ST_EX] & ex_cjmp & ex_taken;
  assign id_live    = stg_vld[ST_ID] & ~ex_take;
  assign of_live    = stg_vld[ST_OF] & ~ex_take;
  assign mem_claim  = of_live & of_memreq;
  assign ex_wr_live = stg_vld[ST_EX] & ex_wr;
  assign set_en     = id_live & id_wr & id_go & (id_rd != '0);
  assign clr_en     = stg_vld[ST_SR] & sr_wr;

  hzd_lock_tbl #(.NREG(NREG)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_idx(id_rd),
    .clr_en(clr_en), .clr_idx(sr_rd),
    .lock_q(lock_q)
  );

  hzd_dep_chk #(.NREG(NREG)) u_dep (
    .fwd_en(fwd_en), .lock_q(lock_q), .of_live(of_live),
    .use_v({of_use_b, of_use_a}), .rs_v({of_rs_b, of_rs_a}),
    .ex_wr_live(ex_wr_live), .ex_rd(ex_rd),
    .id_wr_live(id_live & id_wr), .id_rd(id_rd),
    .fwd_v(fwd_v), .raw_hold(raw_hold), .waw_hold(waw_hold)
  );

  hzd_seq_ctl u_seq (
    .ex_take(ex_take), .id_jmp(id_live & id_ujmp), .mem_claim(mem_claim),
    .waw_hold(waw_hold), .raw_hold(raw_hold),
    .stall(stall), .flush(flush), .bubble(bubble),
    .redirect(redirect), .redirect_ex(redirect_ex), .id_go(id_go)
  );

  assign fwd_a = fwd_v[0];
  assign fwd_b = fwd_v[1];

  AST_FWD_BOTH_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a && fwd_b && !waw_hold) |-> !stall[ST_OF]); // R3
  AST_R0_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a |-> (of_rs_a != '0)); // R4
  AST_TAKEN_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    ex_take |-> (flush == SQ_EX && stall == '0 && redirect_ex)); // R8
  AST_REDIR_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> flush[ST_IF]); // R6
  AST_SQUASH_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_take && id_wr && !lock_q[id_rd]) |=> !lock_q[$past(id_rd)]); // R8
endmodule

// File: tb/tb_hzd_ctl.sv
`timescale 1ns/1ps
module tb_hzd_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] stg_vld;
  logic       id_wr, id_ujmp, of_use_a, of_use_b, of_memreq, ex_wr, ex_cjmp, ex_taken, sr_wr, fwd_en;
  logic [2:0] id_rd, of_rs_a, of_rs_b, ex_rd, sr_rd;
  logic [4:0] stall, flush, bubble;
  logic       redirect, redirect_ex, fwd_a, fwd_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [4:0] st, fl, bu;
    logic       rd, rx, fa, fb;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  hzd_ctl dut (
    .clk(clk), .rst_n(rst_n), .stg_vld(stg_vld),
    .id_wr(id_wr), .id_rd(id_rd), .id_ujmp(id_ujmp),
    .of_use_a(of_use_a), .of_rs_a(of_rs_a), .of_use_b(of_use_b), .of_rs_b(of_rs_b),
    .of_memreq(of_memreq), .ex_wr(ex_wr), .ex_rd(ex_rd), .ex_cjmp(ex_cjmp),
    .ex_taken(ex_taken), .sr_wr(sr_wr), .sr_rd(sr_rd), .fwd_en(fwd_en),
    .stall(stall), .flush(flush), .bubble(bubble), .redirect(redirect),
    .redirect_ex(redirect_ex), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  task automatic zero_in();
    stg_vld = '0; id_wr = 0; id_rd = 0; id_ujmp = 0; of_use_a = 0; of_rs_a = 0;
    of_use_b = 0; of_rs_b = 0; of_memreq = 0; ex_wr = 0; ex_rd = 0; ex_cjmp = 0;
    ex_taken = 0; sr_wr = 0; sr_rd = 0;
  endtask

  // Driver: inputs are already applied at this falling edge; queue expectation, advance a cycle
  task automatic expect_cyc(string tag, logic [4:0] st, logic [4:0] fl, logic [4:0] bu,
                            logic rd, logic rx, logic fa, logic fb);
    exp_t e;
    e.tag = tag; e.st = st; e.fl = fl; e.bu = bu; e.rd = rd; e.rx = rx; e.fa = fa; e.fb = fb;
    sb.push_back(e);
    @(negedge clk);
    zero_in();
  endtask

  // Monitor: pops and compares 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (stall !== e.st || flush !== e.fl || bubble !== e.bu || redirect !== e.rd ||
          redirect_ex !== e.rx || fwd_a !== e.fa || fwd_b !== e.fb) begin
        n_fail++;
        $display("FAIL %s: got st=%b fl=%b bu=%b rd=%b rx=%b fa=%b fb=%b exp st=%b fl=%b bu=%b rd=%b rx=%b fa=%b fb=%b",
                 e.tag, stall, flush, bubble, redirect, redirect_ex, fwd_a, fwd_b,
                 e.st, e.fl, e.bu, e.rd, e.rx, e.fa, e.fb);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    zero_in(); fwd_en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_cyc("R1 idle", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    stg_vld[2] = 1; of_use_a = 1; of_rs_a = 5; of_use_b = 1; of_rs_b = 6;
    expect_cyc("R1 reader no lock", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    // R2 lock and release
    stg_vld[1] = 1; id_wr = 1; id_rd = 3;
    expect_cyc("R2 set r3", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    stg_vld[2] = 1; of_use_a = 1; of_rs_a = 3;
    expect_cyc("R2 raw stall", 5'b00111, 5'b0, 5'b01000, 0, 0, 0, 0);
    stg_vld = 5'b10100; of_use_a = 1; of_rs_a = 3; sr_wr = 1; sr_rd = 3;
    expect_cyc("R2 stall during retire", 5'b00111, 5'b0, 5'b01000, 0, 0, 0, 0);
    stg_vld[2] = 1; of_use_a = 1; of_rs_a = 3;
    expect_cyc("R2 released", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    // R3 forwarding
    stg_vld[1] = 1; id_wr = 1; id_rd = 4;
    expect_cyc("R3 set r4", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    fwd_en = 1; stg_vld = 5'b01100; ex_wr = 1; ex_rd = 4; of_use_b = 1; of_rs_b = 4;
    expect_cyc("R3 fwd b", 5'b0, 5'b0, 5'b0, 0, 0, 0, 1);
    fwd_en = 0; stg_vld = 5'b01100; ex_wr = 1; ex_rd = 4; of_use_b = 1; of_rs_b = 4;
    expect_cyc("R3 no fwd stalls", 5'b00111, 5'b0, 5'b01000, 0, 0, 0, 0);
    fwd_en = 1; stg_vld = 5'b11100; ex_wr = 1; ex_rd = 4; of_use_a = 1; of_rs_a = 4;
    of_use_b = 1; of_rs_b = 4; sr_wr = 1; sr_rd = 4;
    expect_cyc("R3 fwd both", 5'b0, 5'b0, 5'b0, 0, 0, 1, 1);
    // R4 register zero
    stg_vld = 5'b01100; ex_wr = 1; ex_rd = 0; of_use_a = 1; of_rs_a = 0;
    expect_cyc("R4 no fwd r0", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    fwd_en = 0; stg_vld[1] = 1; id_wr = 1; id_rd = 0;
    expect_cyc("R4 write r0", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    stg_vld[2] = 1; of_use_a = 1; of_rs_a = 0;
    expect_cyc("R4 read r0", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    // R5 memory port
    stg_vld[2] = 1; of_memreq = 1;
    expect_cyc("R5 mem claim", 5'b00001, 5'b0, 5'b00010, 0, 0, 0, 0);
    stg_vld[1] = 1; id_wr = 1; id_rd = 2;
    expect_cyc("R10 set r2", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    stg_vld[2] = 1; of_use_a = 1; of_rs_a = 2; of_memreq = 1;
    expect_cyc("R10 raw plus mem", 5'b00111, 5'b0, 5'b01000, 0, 0, 0, 0);
    // R6 unconditional jump
    stg_vld[1] = 1; id_ujmp = 1;
    expect_cyc("R6 ujmp", 5'b0, 5'b00001, 5'b0, 1, 0, 0, 0);
    stg_vld = 5'b00110; id_ujmp = 1; of_memreq = 1;
    expect_cyc("R8 ujmp over mem", 5'b0, 5'b00001, 5'b0, 1, 0, 0, 0);
    stg_vld = 5'b00110; id_ujmp = 1; of_use_a = 1; of_rs_a = 2;
    expect_cyc("R6 ujmp held", 5'b00111, 5'b0, 5'b01000, 0, 0, 0, 0);
    // R7 conditional jump
    stg_vld[3] = 1; ex_cjmp = 1; ex_taken = 1;
    expect_cyc("R7 taken", 5'b0, 5'b00111, 5'b0, 1, 1, 0, 0);
    stg_vld[3] = 1; ex_cjmp = 1;
    expect_cyc("R7 not taken", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    // R8 squash beats everything
    stg_vld = 5'b01110; ex_cjmp = 1; ex_taken = 1; of_use_a = 1; of_rs_a = 2;
    of_memreq = 1; id_wr = 1; id_rd = 6;
    expect_cyc("R8 taken over holds", 5'b0, 5'b00111, 5'b0, 1, 1, 0, 0);
    stg_vld[2] = 1; of_use_a = 1; of_rs_a = 6;
    expect_cyc("R8 squashed no lock", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    stg_vld[4] = 1; sr_wr = 1; sr_rd = 2;
    expect_cyc("R2 clear r2", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    // R9 write after write
    stg_vld[1] = 1; id_wr = 1; id_rd = 1;
    expect_cyc("R9 set r1", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    stg_vld[1] = 1; id_wr = 1; id_rd = 1;
    expect_cyc("R9 waw hold", 5'b00011, 5'b0, 5'b00100, 0, 0, 0, 0);
    stg_vld = 5'b10010; id_wr = 1; id_rd = 1; sr_wr = 1; sr_rd = 1;
    expect_cyc("R9 hold during retire", 5'b00011, 5'b0, 5'b00100, 0, 0, 0, 0);
    stg_vld[1] = 1; id_wr = 1; id_rd = 1;
    expect_cyc("R9 waw proceeds", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    stg_vld = 5'b10010; id_wr = 1; id_rd = 7; sr_wr = 1; sr_rd = 7;
    expect_cyc("R9 set and clear", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    stg_vld[2] = 1; of_use_b = 1; of_rs_b = 7;
    expect_cyc("R9 set wins", 5'b00111, 5'b0, 5'b01000, 0, 0, 0, 0);
    stg_vld[4] = 1; sr_wr = 1; sr_rd = 7;
    expect_cyc("R2 clear r7", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    stg_vld[2] = 1; of_use_b = 1; of_rs_b = 1;
    expect_cyc("R9 r1 still locked", 5'b00111, 5'b0, 5'b01000, 0, 0, 0, 0);
    stg_vld[4] = 1; sr_wr = 1; sr_rd = 1;
    expect_cyc("R2 clear r1", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    stg_vld[2] = 1; of_use_a = 1; of_rs_a = 1; of_use_b = 1; of_rs_b = 7;
    expect_cyc("R2 all released", 5'b0, 5'b0, 5'b0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule